// File: doc/BRIEF.md
# Drain-Source Short Fault Qualifier

This block watches the drain-source voltage comparators of a half-bridge's high-side and low-side power switches. A side is checked only while its gate is commanded on. Comparator trips are qualified over a programmable time before they are latched as short-circuit faults. Each side has its own latched fault bit. Their OR forms a fault flag, and this flag, together with a sleep request, forces the bridge off.

A 6-bit qualify code sets the time in 100 ns units, which is two cycles of the 20 MHz system clock, so the range is 0 to 6.3 µs. One mode bit chooses how that time is used. In blank mode the comparator is not looked at for the qualify time after turn-on, and any trip after that window latches at once. In debounce mode the comparator must stay asserted without a break for the qualify time before it latches. An active-low clear line removes latched faults when it carries a pulse of sufficient width. If the line is held low much longer, the block raises a sleep request.

Top module: `vds_short_mon`

## Requirements
- R1: After reset, both side fault bits, the fault flag, the bridge-off output and the sleep request are 0.
- R2: A side's comparator is ignored while that side's gate input is 0, and the side's qualify counter restarts from zero each time the gate input is 0.
- R3: The qualify length q in clock cycles is the code multiplied by 2 (100 ns per code step at 20 MHz). A code of 0 gives q = 0, so a trip latches on the first sampled edge where both the gate and the comparator are 1.
- R4: In blank mode (mode input = 1), the first q rising-edge samples after the gate turns on are ignored. At any later sample where both the gate and the comparator are 1, the fault bit is set on that edge.
- R5: In debounce mode (mode input = 0), the fault sets only when q+1 consecutive samples have both the gate and the comparator at 1. A single sample with the comparator at 0 restarts the count.
- R6: A set fault bit stays at 1 after the comparator and the gate return to 0, until a clear is accepted.
- R7: The two sides qualify and latch independently. The fault flag is the OR of the two fault bits, and the bridge-off output is the fault flag OR the sleep request.
- R8: A clear is accepted when the clear input is sampled low for at least 10 consecutive edges and then sampled high. Fault bits drop on the second edge after the first high sample. A low pulse of 9 or fewer samples clears nothing.
- R9: The sleep request goes to 1 once the clear input has been sampled low on 600 consecutive edges (30 µs). It returns to 0 on the first edge that samples the input high.
- R10: If a qualified trip and an accepted clear fall on the same edge, the fault bit stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 20 MHz system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_gate_i | input | 1 | High-side gate commanded on |
| ls_gate_i | input | 1 | Low-side gate commanded on |
| hs_cmp_i | input | 1 | High-side drain-source comparator over threshold |
| ls_cmp_i | input | 1 | Low-side drain-source comparator over threshold |
| qual_code_i | input | 6 | Qualify time in 100 ns steps |
| blank_mode_i | input | 1 | 1 = blank after turn-on, 0 = debounce |
| clr_ni | input | 1 | Fault clear / sleep line, active low |
| hs_flt_o | output | 1 | Latched high-side short fault |
| ls_flt_o | output | 1 | Latched low-side short fault |
| flt_any_o | output | 1 | OR of the side faults |
| bridge_off_o | output | 1 | Forces both gates off |
| sleep_req_o | output | 1 | Clear line held low long enough to request sleep |

## Verification
A latching trip and an accepted clear can land on the same clock edge. The bench sets a fault, then keeps the gate and comparator asserted while a clear pulse of valid width is released. It samples the fault bit just after the edge where the clear acts. A 1 there shows that the set path wins, while a clear-first design would show a one-cycle drop. The blanking and debounce edges are then checked one sample either side of q, so a single-cycle shift in either counter compare is exposed.

// File: rtl/vds_mon_pkg.sv
package vds_mon_pkg;
  localparam int QCODE_W = 6;
  localparam int N_SIDES = 2;
  localparam int SIDE_HS = 0;
  localparam int SIDE_LS = 1;

  typedef enum logic {
    QM_DEBOUNCE = 1'b0,
    QM_BLANK    = 1'b1
  } qmode_e;
endpackage

// File: rtl/vds_mon_chan.sv
module vds_mon_chan
  import vds_mon_pkg::*;
#(
  parameter int CODE_W   = QCODE_W,
  parameter int STEP_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gate_i,
  input  logic              cmp_i,
  input  logic [CODE_W-1:0] code_i,
  input  qmode_e            mode_i,
  input  logic              clr_i,
  output logic              flt_o
);
  localparam int QMAX  = ((1 << CODE_W) - 1) * STEP_CYC;
  localparam int CNT_W = $clog2(QMAX + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, q_len;
  logic             reached, hit, flt_q;

  assign q_len   = CNT_W'(code_i) * CNT_W'(STEP_CYC);
  assign reached = (cnt_q >= q_len);

  always_comb begin
    cnt_d = cnt_q;
    hit   = 1'b0;
    if (!gate_i) begin
      cnt_d = '0;
    end else if (mode_i == QM_BLANK) begin
      // window runs from turn-on regardless of comparator
      hit = reached & cmp_i;
      if (!reached) cnt_d = cnt_q + CNT_W'(1);
    end else begin
      if (!cmp_i) begin
        cnt_d = '0;
      end else begin
        hit = reached;
        if (!reached) cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      flt_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      // set has priority over clear
      if (hit)        flt_q <= 1'b1;
      else if (clr_i) flt_q <= 1'b0;
    end
  end

  assign flt_o = flt_q;
endmodule

// File: rtl/vds_mon_clr_filt.sv
module vds_mon_clr_filt #(
  parameter int CLR_MIN_CYC = 10,
  parameter int SLEEP_CYC   = 600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_ni,
  output logic clr_o,
  output logic sleep_o
);
  localparam int CNT_W = $clog2(SLEEP_CYC + 1);

  logic [CNT_W-1:0] low_cnt_q;
  logic             clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
      clr_q     <= 1'b0;
    end else if (!clr_ni) begin
      clr_q <= 1'b0;
      if (low_cnt_q != CNT_W'(SLEEP_CYC)) low_cnt_q <= low_cnt_q + CNT_W'(1);
    end else begin
      clr_q     <= (low_cnt_q >= CNT_W'(CLR_MIN_CYC));
      low_cnt_q <= '0;
    end
  end

  assign clr_o   = clr_q;
  assign sleep_o = (low_cnt_q >= CNT_W'(SLEEP_CYC));
endmodule

// File: rtl/vds_short_mon.sv
module vds_short_mon
  import vds_mon_pkg::*;
#(
  parameter int CODE_W      = QCODE_W,
  parameter int STEP_CYC    = 2,
  parameter int CLR_MIN_CYC = 10,
  parameter int SLEEP_CYC   = 600
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hs_gate_i,
  input  logic              ls_gate_i,
  input  logic              hs_cmp_i,
  input  logic              ls_cmp_i,
  input  logic [CODE_W-1:0] qual_code_i,
  input  logic              blank_mode_i,
  input  logic              clr_ni,
  output logic              hs_flt_o,
  output logic              ls_flt_o,
  output logic              flt_any_o,
  output logic              bridge_off_o,
  output logic              sleep_req_o
);
  logic [N_SIDES-1:0] gate_v, cmp_v, flt_v;
  logic               clr_pulse, sleep;
  qmode_e             mode;

  assign gate_v[SIDE_HS] = hs_gate_i;
  assign gate_v[SIDE_LS] = ls_gate_i;
  assign cmp_v[SIDE_HS]  = hs_cmp_i;
  assign cmp_v[SIDE_LS]  = ls_cmp_i;
  assign mode            = qmode_e'(blank_mode_i);

  vds_mon_clr_filt #(
    .CLR_MIN_CYC(CLR_MIN_CYC),
    .SLEEP_CYC  (SLEEP_CYC)
  ) u_clr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_ni (clr_ni),
    .clr_o  (clr_pulse),
    .sleep_o(sleep)
  );

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    vds_mon_chan #(
      .CODE_W  (CODE_W),
      .STEP_CYC(STEP_CYC)
    ) u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .gate_i(gate_v[s]),
      .cmp_i (cmp_v[s]),
      .code_i(qual_code_i),
      .mode_i(mode),
      .clr_i (clr_pulse),
      .flt_o (flt_v[s])
    );
  end

  assign hs_flt_o     = flt_v[SIDE_HS];
  assign ls_flt_o     = flt_v[SIDE_LS];
  assign flt_any_o    = |flt_v;
  assign bridge_off_o = flt_any_o | sleep;
  assign sleep_req_o  = sleep;
endmodule

// File: rtl/vds_short_mon_chk.sv
module vds_short_mon_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic hs_gate_i,
  input logic ls_gate_i,
  input logic hs_cmp_i,
  input logic ls_cmp_i,
  input logic clr_ni,
  input logic hs_flt_o,
  input logic ls_flt_o,
  input logic sleep_req_o
);
  AST_HS_SET_NEEDS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_flt_o) |-> $past(hs_gate_i)); // R2
  AST_HS_SET_NEEDS_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_flt_o) |-> $past(hs_cmp_i)); // R4
  AST_LS_SET_NEEDS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_flt_o) |-> ($past(ls_gate_i) && $past(ls_cmp_i))); // R7
  AST_HS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_flt_o && $past(clr_ni) && $past(clr_ni, 2)) |=> hs_flt_o); // R6
  AST_LS_DROP_AFTER_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ls_flt_o) |-> ($past(clr_ni) && $past(clr_ni, 2))); // R8
  AST_SLEEP_WHILE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_req_o |-> !$past(clr_ni)); // R9
endmodule

bind vds_short_mon vds_short_mon_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hs_gate_i  (hs_gate_i),
  .ls_gate_i  (ls_gate_i),
  .hs_cmp_i   (hs_cmp_i),
  .ls_cmp_i   (ls_cmp_i),
  .clr_ni     (clr_ni),
  .hs_flt_o   (hs_flt_o),
  .ls_flt_o   (ls_flt_o),
  .sleep_req_o(sleep_req_o)
);

// File: tb/vds_short_mon_bench.sv
module vds_short_mon_bench;
  localparam int CLK_PERIOD = 50;
  localparam int N_VEC = 12;

  typedef struct packed {
    logic       blank;
    logic       side;   // 0 = high side, 1 = low side
    logic [5:0] code;
    logic [7:0] start;
    logic [7:0] len;
    logic [7:0] gate;
    logic       exp;
  } vec_t;

  localparam vec_t VECS [N_VEC] = '{
    '{1'b1, 1'b0, 6'd16, 8'd0,  8'd20,  8'd60,  1'b0}, // R4 trip inside window
    '{1'b1, 1'b0, 6'd16, 8'd0,  8'd40,  8'd60,  1'b1}, // R4 trip outlasts window
    '{1'b1, 1'b1, 6'd16, 8'd32, 8'd1,   8'd60,  1'b1}, // R4 first sample after window
    '{1'b1, 1'b1, 6'd16, 8'd31, 8'd1,   8'd60,  1'b0}, // R4 last blanked sample
    '{0,    1'b0, 6'd16, 8'd5,  8'd32,  8'd60,  1'b0}, // R5 one short of q+1
    '{0,    1'b1, 6'd16, 8'd5,  8'd33,  8'd60,  1'b1}, // R5 exactly q+1
    '{0,    1'b0, 6'd0,  8'd3,  8'd1,   8'd10,  1'b1}, // R3 code 0 debounce
    '{1'b1, 1'b1, 6'd0,  8'd0,  8'd1,   8'd10,  1'b1}, // R3 code 0 blank
    '{0,    1'b0, 6'd63, 8'd0,  8'd127, 8'd140, 1'b1}, // R3 max code
    '{0,    1'b1, 6'd63, 8'd0,  8'd126, 8'd140, 1'b0}, // R3 max code short
    '{1'b1, 1'b0, 6'd5,  8'd9,  8'd1,   8'd20,  1'b0}, // R3 code 5 q=10
    '{1'b1, 1'b0, 6'd5,  8'd10, 8'd1,   8'd20,  1'b1}  // R3 code 5 q=10
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic hs_gate_i = 1'b0, ls_gate_i = 1'b0, hs_cmp_i = 1'b0, ls_cmp_i = 1'b0;
  logic [5:0] qual_code_i = 6'd16;
  logic blank_mode_i = 1'b1;
  logic clr_ni = 1'b1;
  logic hs_flt_o, ls_flt_o, flt_any_o, bridge_off_o, sleep_req_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  vds_short_mon u_vds_short_mon (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hs_gate_i   (hs_gate_i),
    .ls_gate_i   (ls_gate_i),
    .hs_cmp_i    (hs_cmp_i),
    .ls_cmp_i    (ls_cmp_i),
    .qual_code_i (qual_code_i),
    .blank_mode_i(blank_mode_i),
    .clr_ni      (clr_ni),
    .hs_flt_o    (hs_flt_o),
    .ls_flt_o    (ls_flt_o),
    .flt_any_o   (flt_any_o),
    .bridge_off_o(bridge_off_o),
    .sleep_req_o (sleep_req_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic side, input logic g, input logic c);
    if (side) begin ls_gate_i = g; ls_cmp_i = c; end
    else      begin hs_gate_i = g; hs_cmp_i = c; end
  endtask

  task automatic idle(input int n);
    hs_gate_i = 0; ls_gate_i = 0; hs_cmp_i = 0; ls_cmp_i = 0;
    repeat (n) @(negedge clk_i);
  endtask

  // n low samples, then release; faults drop after the second high edge
  task automatic pulse_clr(input int n);
    clr_ni = 1'b0;
    repeat (n) @(negedge clk_i);
    clr_ni = 1'b1;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic run(input logic blank, input logic side, input logic [5:0] code,
                     input int start, input int len, input int gate);
    blank_mode_i = blank;
    qual_code_i  = code;
    for (int i = 0; i < gate; i++) begin
      drive(side, 1'b1, (i >= start) && (i < start + len));
      @(negedge clk_i);
    end
    idle(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 hs_flt", hs_flt_o, 1'b0);
    chk("R1 ls_flt", ls_flt_o, 1'b0);
    chk("R1 flt_any", flt_any_o, 1'b0);
    chk("R1 bridge_off", bridge_off_o, 1'b0);
    chk("R1 sleep", sleep_req_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int v = 0; v < N_VEC; v++) begin
      pulse_clr(12);
      run(VECS[v].blank, VECS[v].side, VECS[v].code,
          int'(VECS[v].start), int'(VECS[v].len), int'(VECS[v].gate));
      chk($sformatf("R4/R5 vec%0d own side", v),
          VECS[v].side ? ls_flt_o : hs_flt_o, VECS[v].exp);
      chk($sformatf("R7 vec%0d other side", v),
          VECS[v].side ? hs_flt_o : ls_flt_o, 1'b0);
      chk($sformatf("R7 vec%0d flt_any", v), flt_any_o, VECS[v].exp);
      chk($sformatf("R7 vec%0d bridge_off", v), bridge_off_o, VECS[v].exp);
    end

    // R2 comparators with gates off
    pulse_clr(12);
    blank_mode_i = 1'b1; qual_code_i = 6'd0;
    hs_cmp_i = 1; ls_cmp_i = 1;
    repeat (50) @(negedge clk_i);
    chk("R2 hs gate off", hs_flt_o, 1'b0);
    chk("R2 ls gate off", ls_flt_o, 1'b0);
    idle(2);

    // R5 gap restarts debounce
    run(1'b0, 1'b0, 6'd16, 0, 20, 20);
    run(1'b0, 1'b0, 6'd16, 0, 20, 20);
    chk("R5 gap restart", hs_flt_o, 1'b0);

    // R2 gate off restarts blank window
    blank_mode_i = 1'b0; qual_code_i = 6'd16; blank_mode_i = 1'b1;
    for (int i = 0; i < 20; i++) begin drive(1'b1, 1'b1, 1'b0); @(negedge clk_i); end
    drive(1'b1, 1'b0, 1'b0); @(negedge clk_i);
    for (int i = 0; i < 40; i++) begin drive(1'b1, 1'b1, i < 32); @(negedge clk_i); end
    idle(3);
    chk("R2 blank restart", ls_flt_o, 1'b0);

    // R6 latch, R8 short pulse ignored then valid pulse
    run(1'b1, 1'b0, 6'd0, 0, 1, 2);
    idle(50);
    chk("R6 latched", hs_flt_o, 1'b1);
    pulse_clr(9);
    chk("R8 short pulse", hs_flt_o, 1'b1);
    pulse_clr(10);
    chk("R8 valid pulse", hs_flt_o, 1'b0);

    // R7 both sides
    run(1'b1, 1'b0, 6'd0, 0, 1, 2);
    run(1'b1, 1'b1, 6'd0, 0, 1, 2);
    chk("R7 both hs", hs_flt_o, 1'b1);
    chk("R7 both ls", ls_flt_o, 1'b1);
    pulse_clr(12);
    chk("R7 cleared any", flt_any_o, 1'b0);

    // R9 sleep request
    clr_ni = 1'b0;
    repeat (590) @(negedge clk_i);
    chk("R9 sleep before", sleep_req_o, 1'b0);
    repeat (20) @(negedge clk_i);
    chk("R9 sleep after", sleep_req_o, 1'b1);
    chk("R7 bridge_off by sleep", bridge_off_o, 1'b1);
    clr_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 sleep released", sleep_req_o, 1'b0);
    chk("R9 bridge_off released", bridge_off_o, 1'b0);

    // R10 trip held through clear release
    blank_mode_i = 1'b1; qual_code_i = 6'd0;
    drive(1'b0, 1'b1, 1'b1);
    repeat (3) @(negedge clk_i);
    pulse_clr(12);
    chk("R10 set wins", hs_flt_o, 1'b1);
    idle(2);
    pulse_clr(12);
    chk("R8 clear after trip", hs_flt_o, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule